// File: doc/BRIEF.md
# Clock Source Switch Controller

This block chooses the system clock from two sources: a primary oscillator path and an internal RC oscillator. A 2-bit select field asks for one or the other. Moving to the RC source hands the clock over without glitches and then turns the primary oscillator off. Moving back turns the primary oscillator on first. The block counts a start-up interval on the primary clock, adds a lock interval when the PLL is in use, and keeps the system on the RC clock the whole time. Only after the count is done does it hand the clock over. A status flag reports whether the primary source is driving the system.

The control state machine runs on the RC clock, which always runs during a transition. The hand-over mux has one enable leg per clock domain. Each leg arms on a rising edge and commits on a falling edge, and a leg may arm only while the other leg is off. The start-up counter is cleared without a clock whenever the primary oscillator is disabled. An abandoned start-up therefore always begins again from zero. The RC oscillator enable output stays high while a watchdog or clock-monitor enable asks for it, as well as whenever the RC clock is needed for switching.

Top module: `clk_source_switch`

## Requirements
- R1: A select value of 2'b11 requests the RC source. Each of 2'b00, 2'b01 and 2'b10 requests the primary source.
- R2: When a switch to the RC source completes, `pri_osc_en` is 0 and `pri_active` is 0.
- R3: While the primary oscillator is starting up, `sys_clk` follows `clk_rc` and `pri_active` stays 0.
- R4: After `pri_osc_en` rises, the switch to the primary source happens no earlier than OST_CYCLES (default 1024) rising edges of `clk_pri`. It completes within a bounded number of further edges.
- R5: With `pll_en` high, a further PLL_LOCK_CYCLES primary edges are added before the switch.
- R6: When the switch to the primary source completes, `pri_active` is 1 and `sys_clk` follows `clk_pri`.
- R7: `sys_clk` never shows a high or low phase shorter than the shorter half-period of the two sources. The two mux legs are never enabled at the same time.
- R8: `rc_osc_en` is 1 whenever `wdog_en` or `clkmon_en` is 1, the select requests RC, or the primary source is not steadily driving. Otherwise it is 0.
- R9: If the select goes back to RC during a pending start-up, the primary oscillator is disabled and the flag stays 0. A later request for the primary source then takes a full start-up count again.
- R10: After reset, `pri_active` is 0, `pri_osc_en` is 1, `sys_clk` follows `clk_rc`, and the start-up count toward the primary source begins from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pri | input | 1 | Primary oscillator clock (runs only while enabled) |
| clk_rc | input | 1 | Internal RC oscillator clock; also clocks the control logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 2 | Source request; 2'b11 = RC, other values = primary |
| pll_en | input | 1 | Adds the PLL lock interval to the start-up count |
| wdog_en | input | 1 | Watchdog enable; keeps the RC oscillator running |
| clkmon_en | input | 1 | Clock-monitor enable; keeps the RC oscillator running |
| sys_clk | output | 1 | Glitch-free selected system clock |
| pri_osc_en | output | 1 | Primary oscillator enable |
| rc_osc_en | output | 1 | RC oscillator enable |
| pri_active | output | 1 | Status flag: primary source drives `sys_clk` |

## Verification
The hard case is when the start-up timer reports ready in the same cycle that the select returns to RC. Here the completion of a start-up meets its abandonment. The bench provokes this collision by sweeping the moment of the select change in small steps across the expected ready point. After each step it checks that the block settles on the RC source, with the primary oscillator off and the flag clear. It also checks that no runt phase ever appears on `sys_clk`. Randomly timed sequences of select, PLL and enable changes add further collisions between a hand-over in flight and a new request.

// File: rtl/cks_pkg.sv
package cks_pkg;

  localparam logic [1:0] SEL_RC = 2'b11;

  typedef enum logic [2:0] {
    CS_WARM   = 3'd0,
    CS_TO_PRI = 3'd1,
    CS_PRI    = 3'd2,
    CS_TO_RC  = 3'd3,
    CS_RC     = 3'd4
  } cks_state_e;

  function automatic logic sel_wants_rc(input logic [1:0] s);
    return (s == SEL_RC);
  endfunction

  function automatic logic st_mux_rc(input cks_state_e s);
    return (s == CS_WARM) || (s == CS_TO_RC) || (s == CS_RC);
  endfunction

  function automatic logic st_flag(input cks_state_e s);
    return (s == CS_PRI) || (s == CS_TO_RC);
  endfunction

  function automatic logic st_osc_on(input cks_state_e s);
    return (s != CS_RC);
  endfunction

  function automatic logic st_rc_needed(input cks_state_e s);
    return (s != CS_PRI);
  endfunction

  function automatic int unsigned stu_limit(input int unsigned ost,
                                            input int unsigned pll,
                                            input logic pll_on);
    return pll_on ? (ost + pll) : ost;
  endfunction

endpackage

// File: rtl/cks_sync.sv
module cks_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= {STAGES{RST_VAL}};
    else        sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/cks_mux_leg.sv
module cks_mux_leg #(
  parameter logic RST_ON = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic want,
  input  logic other_on,
  output logic on
);
  logic arm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) arm <= RST_ON;
    else        arm <= want & ~other_on;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) on <= RST_ON;
    else        on <= arm;
  end
endmodule

// File: rtl/cks_glitch_mux.sv
module cks_glitch_mux (
  input  logic clk_a,
  input  logic clk_b,
  input  logic rst_n,
  input  logic pick_b,
  output logic clk_out,
  output logic on_a,
  output logic on_b
);
  cks_mux_leg #(.RST_ON(1'b0)) u_leg_a (
    .clk(clk_a), .rst_n(rst_n), .want(~pick_b), .other_on(on_b), .on(on_a)
  );

  cks_mux_leg #(.RST_ON(1'b1)) u_leg_b (
    .clk(clk_b), .rst_n(rst_n), .want(pick_b), .other_on(on_a), .on(on_b)
  );

  assign clk_out = (clk_a & on_a) | (clk_b & on_b);
endmodule

// File: rtl/cks_startup_timer.sv
module cks_startup_timer
  import cks_pkg::*;
#(
  parameter int unsigned OST_CYCLES      = 1024,
  parameter int unsigned PLL_LOCK_CYCLES = 64,
  parameter int          SYNC_STAGES     = 2
) (
  input  logic clk_pri,
  input  logic run_n,
  input  logic pll_en,
  output logic ready
);
  localparam int unsigned MAX_LIM = OST_CYCLES + PLL_LOCK_CYCLES;
  localparam int          CW      = $clog2(MAX_LIM + 1) + 1;

  logic          run_rel;
  logic          pll_on;
  logic [CW-1:0] cnt;
  logic [CW-1:0] limit_w;

  cks_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rel (
    .clk(clk_pri), .rst_n(run_n), .d(1'b1), .q(run_rel)
  );

  cks_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pll (
    .clk(clk_pri), .rst_n(run_rel), .d(pll_en), .q(pll_on)
  );

  assign limit_w = CW'(stu_limit(OST_CYCLES, PLL_LOCK_CYCLES, pll_on));

  always_ff @(posedge clk_pri or negedge run_rel) begin
    if (!run_rel) begin
      cnt   <= '0;
      ready <= 1'b0;
    end else begin
      if (cnt < limit_w) cnt <= cnt + 1'b1;
      ready <= (cnt >= limit_w);
    end
  end
endmodule

// File: rtl/clk_source_switch.sv
module clk_source_switch
  import cks_pkg::*;
#(
  parameter int unsigned OST_CYCLES      = 1024,
  parameter int unsigned PLL_LOCK_CYCLES = 64,
  parameter int          SYNC_STAGES     = 2
) (
  input  logic       clk_pri,
  input  logic       clk_rc,
  input  logic       rst_n,
  input  logic [1:0] sel,
  input  logic       pll_en,
  input  logic       wdog_en,
  input  logic       clkmon_en,
  output logic       sys_clk,
  output logic       pri_osc_en,
  output logic       rc_osc_en,
  output logic       pri_active
);
  cks_state_e st_q, st_nx;
  logic osc_q, mux_rc_q, flag_q;
  logic want_rc_raw, want_rc_s;
  logic ready_pri, ready_s;
  logic on_pri, on_rc, pri_on_s;
  logic run_n;

  // named internal events
  logic evt_restart, evt_ready_seen, evt_pri_done, evt_rc_done, evt_rc_req, evt_pri_req;

  assign want_rc_raw = sel_wants_rc(sel);

  cks_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_want (
    .clk(clk_rc), .rst_n(rst_n), .d(want_rc_raw), .q(want_rc_s)
  );

  assign run_n = rst_n & osc_q;

  cks_startup_timer #(
    .OST_CYCLES(OST_CYCLES), .PLL_LOCK_CYCLES(PLL_LOCK_CYCLES), .SYNC_STAGES(SYNC_STAGES)
  ) u_tmr (
    .clk_pri(clk_pri), .run_n(run_n), .pll_en(pll_en), .ready(ready_pri)
  );

  cks_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ready (
    .clk(clk_rc), .rst_n(rst_n), .d(ready_pri), .q(ready_s)
  );

  cks_glitch_mux u_mux (
    .clk_a(clk_pri), .clk_b(clk_rc), .rst_n(rst_n), .pick_b(mux_rc_q),
    .clk_out(sys_clk), .on_a(on_pri), .on_b(on_rc)
  );

  cks_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pri_on (
    .clk(clk_rc), .rst_n(rst_n), .d(on_pri), .q(pri_on_s)
  );

  assign evt_restart    = (st_q == CS_WARM) && want_rc_s;
  assign evt_ready_seen = (st_q == CS_WARM) && !want_rc_s && ready_s;
  assign evt_pri_done   = (st_q == CS_TO_PRI) && pri_on_s;
  assign evt_rc_done    = (st_q == CS_TO_RC) && on_rc;
  assign evt_rc_req     = (st_q == CS_PRI) && want_rc_s;
  assign evt_pri_req    = (st_q == CS_RC) && !want_rc_s && !ready_s;

  always_comb begin
    st_nx = st_q;
    unique case (st_q)
      CS_WARM:   if (evt_restart) st_nx = CS_RC;
                 else if (evt_ready_seen) st_nx = CS_TO_PRI;
      CS_TO_PRI: if (evt_pri_done) st_nx = CS_PRI;
      CS_PRI:    if (evt_rc_req)   st_nx = CS_TO_RC;
      CS_TO_RC:  if (evt_rc_done)  st_nx = CS_RC;
      CS_RC:     if (evt_pri_req)  st_nx = CS_WARM;
      default:   st_nx = CS_WARM;
    endcase
  end

  always_ff @(posedge clk_rc or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= CS_WARM;
      osc_q    <= 1'b1;
      mux_rc_q <= 1'b1;
      flag_q   <= 1'b0;
    end else begin
      st_q     <= st_nx;
      osc_q    <= st_osc_on(st_nx);
      mux_rc_q <= st_mux_rc(st_nx);
      flag_q   <= st_flag(st_nx);
    end
  end

  assign pri_osc_en = osc_q;
  assign pri_active = flag_q;
  assign rc_osc_en  = wdog_en | clkmon_en | want_rc_raw | st_rc_needed(st_q);
endmodule

// File: rtl/clk_source_switch_chk.sv
module clk_source_switch_chk (
  input logic clk_rc,
  input logic rst_n,
  input logic pri_active,
  input logic pri_osc_en,
  input logic rc_osc_en,
  input logic on_pri,
  input logic on_rc,
  input logic ready_s,
  input logic sel_rc,
  input logic want_rc_s
);
  AST_MUX_EXCLUSIVE: assert property (@(posedge clk_rc) disable iff (!rst_n)
    !(on_pri && on_rc)); // R7

  AST_FLAG_NEEDS_PRI: assert property (@(posedge clk_rc) disable iff (!rst_n)
    $rose(pri_active) |-> (on_pri && !on_rc)); // R6

  AST_OSC_OFF_ON_RC: assert property (@(posedge clk_rc) disable iff (!rst_n)
    !pri_osc_en |-> (on_rc && !pri_active)); // R2

  AST_RC_RUNS: assert property (@(posedge clk_rc) disable iff (!rst_n)
    !rc_osc_en |-> (pri_active && on_pri)); // R8

  AST_SWAP_AFTER_READY: assert property (@(posedge clk_rc) disable iff (!rst_n)
    $fell(sel_rc) |-> ready_s); // R4

  AST_WARM_ON_RC: assert property (@(posedge clk_rc) disable iff (!rst_n)
    (pri_osc_en && !pri_active && sel_rc) |-> on_rc); // R3

  AST_RESTART_DROPS_OSC: assert property (@(posedge clk_rc) disable iff (!rst_n)
    (pri_osc_en && !pri_active && sel_rc && want_rc_s) |=> !pri_osc_en); // R9
endmodule

bind clk_source_switch clk_source_switch_chk u_chk (
  .clk_rc(clk_rc), .rst_n(rst_n), .pri_active(pri_active), .pri_osc_en(pri_osc_en),
  .rc_osc_en(rc_osc_en), .on_pri(on_pri), .on_rc(on_rc), .ready_s(ready_s),
  .sel_rc(mux_rc_q), .want_rc_s(want_rc_s)
);

// File: tb/clk_source_switch_test.sv
`timescale 1ns/1ps
module clk_source_switch_test;
  localparam int T_OST = 1024;
  localparam int T_PLL = 64;
  localparam int MARGIN = 80;
  localparam real MIN_PHASE = 9.5;

  logic clk_pri = 1'b0, clk_rc = 1'b0, rst_n = 1'b0;
  logic [1:0] sel = 2'b00;
  logic pll_en = 1'b0, wdog_en = 1'b0, clkmon_en = 1'b0;
  logic sys_clk, pri_osc_en, rc_osc_en, pri_active;

  int checks = 0, fails = 0, runts = 0, pri_edges = 0;
  bit mon_en = 1'b0;
  realtime last_t = 0.0;

  clk_source_switch #(.OST_CYCLES(T_OST), .PLL_LOCK_CYCLES(T_PLL), .SYNC_STAGES(2)) uut (
    .clk_pri(clk_pri), .clk_rc(clk_rc), .rst_n(rst_n), .sel(sel), .pll_en(pll_en),
    .wdog_en(wdog_en), .clkmon_en(clkmon_en), .sys_clk(sys_clk),
    .pri_osc_en(pri_osc_en), .rc_osc_en(rc_osc_en), .pri_active(pri_active)
  );

  // primary oscillator model: 50 MHz while enabled
  always begin
    #10;
    if (pri_osc_en === 1'b1) clk_pri = ~clk_pri;
    else clk_pri = 1'b0;
  end
  always #37 clk_rc = ~clk_rc;
  always @(posedge clk_pri) pri_edges++;

  always @(sys_clk) begin
    if (mon_en && (($realtime - last_t) < MIN_PHASE)) runts++;
    last_t = $realtime;
  end

  function automatic int exp_limit(input bit pll);
    return pll ? (T_OST + T_PLL) : T_OST;
  endfunction

  function automatic bit exp_rc_on(input logic [1:0] s, input bit wd, input bit cm, input bit act);
    return wd || cm || (s == 2'b11) || !act;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // returns 1 when sys_clk follows the requested source over several periods
  task automatic follows(input bit use_pri, output bit ok);
    bit hi, lo;
    ok = 1'b1;
    for (int i = 0; i < 4; i++) begin
      if (use_pri) begin
        @(posedge clk_pri); #5; hi = sys_clk;
        @(negedge clk_pri); #5; lo = sys_clk;
      end else begin
        @(posedge clk_rc); #10; hi = sys_clk;
        @(negedge clk_rc); #10; lo = sys_clk;
      end
      if (!(hi && !lo)) ok = 1'b0;
    end
  endtask

  task automatic wait_state(input bit want_pri, output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      @(posedge clk_rc); #10;
      if (want_pri ? (pri_active === 1'b1)
                   : (pri_active === 1'b0 && pri_osc_en === 1'b0)) begin
        ok = 1'b1;
        break;
      end
    end
  endtask

  task automatic measure(input bit pll, input string req);
    int c0, n;
    wait (pri_osc_en === 1'b1);
    c0 = pri_edges;
    repeat (300) @(posedge clk_pri);
    #5;
    chk(pri_active == 1'b0, "R3 flag low during start-up", int'(pri_active), 0);
    begin
      bit f;
      follows(1'b0, f);
      chk(f, "R3 sys_clk on RC during start-up", int'(f), 1);
    end
    wait (pri_active === 1'b1);
    n = pri_edges - c0;
    chk(n >= exp_limit(pll) && n <= exp_limit(pll) + MARGIN, req, n, exp_limit(pll));
  endtask

  initial begin
    #3_000_000;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    bit ok;
    void'($urandom(32'd20240611));
    #200;
    @(negedge clk_rc);
    rst_n = 1'b1;
    #1;
    // R10 reset state
    chk(pri_active == 1'b0, "R10 flag after reset", int'(pri_active), 0);
    chk(pri_osc_en == 1'b1, "R10 primary osc enabled after reset", int'(pri_osc_en), 1);
    follows(1'b0, ok);
    chk(ok, "R10 sys_clk on RC after reset", int'(ok), 1);
    last_t = $realtime;
    mon_en = 1'b1;

    // R4 first start-up, counted from reset
    wait (pri_active === 1'b1);
    chk(pri_edges >= T_OST && pri_edges <= T_OST + MARGIN, "R4 start-up length from reset",
        pri_edges, T_OST);
    follows(1'b1, ok);
    chk(ok, "R6 sys_clk on primary", int'(ok), 1);

    // R8 RC enable in steady primary
    #3; chk(rc_osc_en == 1'b0, "R8 rc off when unneeded", int'(rc_osc_en), 0);
    wdog_en = 1'b1; #3;
    chk(rc_osc_en == 1'b1, "R8 rc on for watchdog", int'(rc_osc_en), 1);
    wdog_en = 1'b0; clkmon_en = 1'b1; #3;
    chk(rc_osc_en == 1'b1, "R8 rc on for clock monitor", int'(rc_osc_en), 1);
    clkmon_en = 1'b0; #3;
    chk(rc_osc_en == 1'b0, "R8 rc off again", int'(rc_osc_en), 0);

    // R1/R2 switch to RC
    sel = 2'b11;
    wait_state(1'b0, ok);
    chk(ok, "R1 sel 11 selects RC", int'(ok), 1);
    chk(pri_osc_en == 1'b0 && pri_active == 1'b0, "R2 osc off and flag clear",
        int'({pri_osc_en, pri_active}), 0);
    follows(1'b0, ok);
    chk(ok, "R2 sys_clk on RC", int'(ok), 1);
    chk(rc_osc_en == 1'b1, "R8 rc on while selected", int'(rc_osc_en), 1);

    // R5 with PLL, select 01
    pll_en = 1'b1; sel = 2'b01;
    measure(1'b1, "R5 start-up with PLL lock");
    chk(pri_active == 1'b1, "R1 sel 01 selects primary", int'(pri_active), 1);

    // R9 restart
    sel = 2'b11; wait_state(1'b0, ok);
    pll_en = 1'b0; sel = 2'b10;
    wait (pri_osc_en === 1'b1);
    repeat (600) @(posedge clk_pri);
    sel = 2'b11;
    wait_state(1'b0, ok);
    chk(ok && pri_active == 1'b0, "R9 abandoned start-up drops osc", int'(ok), 1);
    sel = 2'b00;
    measure(1'b0, "R9 full count after restart");

    // ready versus select change in the same cycle: sweep
    for (int k = 0; k < 12; k++) begin
      sel = 2'b11; wait_state(1'b0, ok);
      sel = 2'b00;
      wait (pri_osc_en === 1'b1);
      repeat (T_OST - 6 + 4 * k) @(posedge clk_pri);
      sel = 2'b11;
      wait_state(1'b0, ok);
      chk(ok, "R9 collision settles on RC", int'(ok), 1);
    end

    // random sequences
    for (int it = 0; it < 20; it++) begin
      logic [1:0] s;
      bit act_exp;
      sel = 2'($urandom_range(0, 3));
      pll_en = 1'($urandom_range(0, 1));
      repeat ($urandom_range(0, 400)) @(posedge clk_rc);
      s = 2'($urandom_range(0, 3));
      sel = s;
      wdog_en = 1'($urandom_range(0, 1));
      clkmon_en = 1'($urandom_range(0, 1));
      act_exp = (s != 2'b11);
      wait_state(act_exp, ok);
      #3;
      chk(ok && pri_active == act_exp, "R1 random final source", int'(pri_active), int'(act_exp));
      chk(rc_osc_en == exp_rc_on(s, wdog_en, clkmon_en, pri_active), "R8 random rc enable",
          int'(rc_osc_en), int'(exp_rc_on(s, wdog_en, clkmon_en, pri_active)));
    end

    chk(runts == 0, "R7 no runt phase on sys_clk", runts, 0);
    finish_run();
  end
endmodule